// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a simple memory-mapped register bus. Software picks a period code, enables the timer and then has to restart it with a fixed key value before the down-counter runs out. Once enabled, the timer cannot be switched off by software; only a block reset does that.

The block has two responses to expiry. In direct mode, expiry asks the system for a reset at once. In interrupt mode, the first expiry only raises a held interrupt and reloads the counter. A second expiry with no restart in between then requests the reset. In interrupt mode the reset therefore comes two full periods after the last restart, which gives a handler one period to react. The reset request is a pulse of fixed width. Reading one dedicated address clears the interrupt. A restart clears both the interrupt and the two-stage tracking.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, both outputs are low, and reads of the control (0x00), range (0x04), count (0x08) and interrupt status (0x10) addresses return zero.
- R2: The period code n selects a reload value of 2^(TOP_BASE+n) - 1. The range register at 0x04 holds the reload code in bits 3:0 and the initial code in bits 7:4, and it reads back as written. Setting the enable bit loads the counter from the initial code.
- R3: While enabled, the counter decrements by one each clock. While disabled, it holds its value, which is 0 after reset.
- R4: The control register at 0x00 holds enable in bit 0 and response mode in bit 1. Once enable is 1, a write of 0 to bit 0 leaves it at 1.
- R5: In direct mode (bit 1 = 0), the clock edge after the count reaches 0 starts a reset pulse `wdt_sys_rst` exactly RST_CYCLES cycles wide. On that same edge the counter reloads from the reload code.
- R6: In interrupt mode (bit 1 = 1), the first expiry raises `wdt_irq` and reloads the counter from the reload code, with no reset pulse. `wdt_irq` then stays high until it is cleared.
- R7: In interrupt mode, a second expiry with no restart since the first one starts the reset pulse.
- R8: A write of 0x76 to 0x0c while enabled is a restart. It reloads the counter from the reload code and clears both the interrupt and the stage tracking. Any other value, or any write while disabled, has no effect.
- R9: A read of 0x14 returns the interrupt status in bit 0 and clears `wdt_irq`, but keeps the stage tracking, so the next expiry still resets. A read of 0x10 returns the same bit without clearing it.
- R10: A read of 0xf4 returns the FIXED_PERIODS parameter in bit 6, with all other bits 0.
- R11: A new reload code written while running does not change the count in progress. It is first used by the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| wdt_irq | output | 1 | Held interrupt after the first expiry in interrupt mode |
| wdt_sys_rst | output | 1 | System reset request pulse |

## Verification
If the stage flag is wrong, the reset pulse appears one period early or one period late, so it shows up within two periods of a restart. If the counter or a reload path is wrong, the count read back is off within one cycle of enable or restart. If the key compare or a clear path is wrong, the interrupt drops too early, or it survives a restart, and this is visible on `wdt_irq` on the very next cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;
  localparam int CODE_W = 4;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RANGE = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 8'h0c;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ICLR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PARAM = 8'hf4;

  localparam logic [DATA_W-1:0] KICK_KEY  = 32'h0000_0076;
  localparam int                FIXED_BIT = 6;

  // Reload value for a period code: 2^(base+code) - 1
  function automatic cnt_t period_of(input code_t code, input int base);
    cnt_t one;
    one = cnt_t'(1);
    return (one << (base + int'(code))) - one;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter bit FIXED_PERIODS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  cnt_t              cnt_val,
  input  logic              irq_lvl,
  output logic              en,
  output logic              rmod,
  output code_t             top_code,
  output code_t             init_code,
  output logic              start_ev,
  output logic              kick_ev,
  output logic              irq_rd_clr,
  output logic [DATA_W-1:0] rdata
);
  logic wr_acc, rd_acc, wr_ctrl, wr_range;

  assign wr_acc   = bus_sel & bus_wr;
  assign rd_acc   = bus_sel & ~bus_wr;
  assign wr_ctrl  = wr_acc && (bus_addr == OFS_CTRL);
  assign wr_range = wr_acc && (bus_addr == OFS_RANGE);

  // internal events brought out for the core and the assertions
  assign start_ev   = wr_ctrl & bus_wdata[0] & ~en;
  assign kick_ev    = wr_acc && (bus_addr == OFS_KICK) && (bus_wdata == KICK_KEY) && en;
  assign irq_rd_clr = rd_acc && (bus_addr == OFS_ICLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      rmod      <= 1'b0;
      top_code  <= '0;
      init_code <= '0;
    end else begin
      if (wr_ctrl) begin
        en   <= en | bus_wdata[0];
        rmod <= bus_wdata[1];
      end
      if (wr_range) begin
        top_code  <= bus_wdata[CODE_W-1:0];
        init_code <= bus_wdata[2*CODE_W-1:CODE_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (bus_addr)
      OFS_CTRL:  rdata[1:0] = {rmod, en};
      OFS_RANGE: rdata[2*CODE_W-1:0] = {init_code, top_code};
      OFS_COUNT: rdata = DATA_W'(cnt_val);
      OFS_STAT:  rdata[0] = irq_lvl;
      OFS_ICLR:  rdata[0] = irq_lvl;
      OFS_PARAM: rdata[FIXED_BIT] = FIXED_PERIODS;
      default:   rdata = '0;
    endcase
  end

  p_en_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int TOP_BASE = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  rmod,
  input  code_t top_code,
  input  code_t init_code,
  input  logic  start_ev,
  input  logic  kick_ev,
  input  logic  irq_rd_clr,
  output cnt_t  cnt,
  output logic  irq,
  output logic  expire_rst
);
  cnt_t reload_top, reload_init;
  logic stage, at_zero, expire_irq;

  assign reload_top  = period_of(top_code, TOP_BASE);
  assign reload_init = period_of(init_code, TOP_BASE);

  assign at_zero    = en && (cnt == '0) && !kick_ev;
  assign expire_irq = at_zero && rmod && !stage;
  assign expire_rst = at_zero && !(rmod && !stage);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      stage <= 1'b0;
      irq   <= 1'b0;
    end else if (start_ev) begin
      cnt   <= reload_init;
      stage <= 1'b0;
      irq   <= 1'b0;
    end else if (kick_ev) begin
      cnt   <= reload_top;
      stage <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (en) begin
        cnt <= (cnt == '0) ? reload_top : cnt - cnt_t'(1);
      end
      if (expire_irq) begin
        stage <= 1'b1;
        irq   <= 1'b1;
      end else begin
        if (expire_rst) stage <= 1'b0;
        if (irq_rd_clr) irq <= 1'b0;
      end
    end
  end

  p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start_ev) |=> $stable(cnt));
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !kick_ev && cnt != '0) |=> cnt == $past(cnt) - cnt_t'(1));
  p_kick_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ev |=> (cnt == $past(reload_top)) && !irq);
  p_irq_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !kick_ev && !irq_rd_clr) |=> irq);
  p_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_rst && rmod) |-> stage);
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int PW = $clog2(RST_CYCLES + 1);
  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)                  left <= '0;
    else if (trig && left == '0) left <= PW'(RST_CYCLES);
    else if (left != '0)         left <= left - PW'(1);
  end

  assign pulse = (left != '0);

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !pulse) |=> pulse);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int TOP_BASE      = 16,
  parameter int RST_CYCLES    = 8,
  parameter bit FIXED_PERIODS = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_irq,
  output logic        wdt_sys_rst
);
  logic  en, rmod, start_ev, kick_ev, irq_rd_clr, expire_rst;
  code_t top_code, init_code;
  cnt_t  cnt;

  wdt_regs #(.FIXED_PERIODS(FIXED_PERIODS)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt), .irq_lvl(wdt_irq),
    .en(en), .rmod(rmod), .top_code(top_code), .init_code(init_code),
    .start_ev(start_ev), .kick_ev(kick_ev), .irq_rd_clr(irq_rd_clr), .rdata(bus_rdata)
  );

  wdt_core #(.TOP_BASE(TOP_BASE)) core_i (
    .clk(clk), .rst_n(rst_n), .en(en), .rmod(rmod), .top_code(top_code),
    .init_code(init_code), .start_ev(start_ev), .kick_ev(kick_ev),
    .irq_rd_clr(irq_rd_clr), .cnt(cnt), .irq(wdt_irq), .expire_rst(expire_rst)
  );

  wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) pulse_i (
    .clk(clk), .rst_n(rst_n), .trig(expire_rst), .pulse(wdt_sys_rst)
  );

  p_rst_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_sys_rst) |-> en);
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb_top;
  localparam int BASE = 4;
  localparam int RSTW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_sys_rst;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wdt_two_stage #(.TOP_BASE(BASE), .RST_CYCLES(RSTW), .FIXED_PERIODS(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_sys_rst(wdt_sys_rst)
  );

  function automatic int unsigned per(input int code);
    return (32'd1 << (BASE + code)) - 1;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    check("R1 irq", 32'(wdt_irq), 0);
    check("R1 sys_rst", 32'(wdt_sys_rst), 0);
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h04, v); check("R1 range", v, 0);
    rd(8'h08, v); check("R1 count", v, 0);
    rd(8'h10, v); check("R1 status", v, 0);
    rd(8'hf4, v); check("R10 fixed flag", v, 32'h40);
  endtask

  task automatic t_direct_mode();
    logic [31:0] v;
    int hi;
    do_reset();
    wr(8'h04, 32'h21);
    rd(8'h04, v); check("R2 range readback", v, 32'h21);
    wr(8'h0c, 32'h76);
    rd(8'h08, v); check("R8 kick while disabled, R3 hold", v, 0);
    wr(8'h00, 32'h1);                                   // edge E0
    rd(8'h08, v); check("R2 initial load", v, per(2));  // edge E0+1
    wr(8'h00, 32'h0);                                   // E0+2
    rd(8'h00, v); check("R4 enable sticky", v, 1);      // E0+3
    rd(8'h08, v); check("R3 decrement", v, per(2) - 3); // E0+4
    wr(8'h0c, 32'h75);                                  // E0+5
    rd(8'h08, v); check("R8 wrong key ignored", v, per(2) - 5); // E0+6
    wait_n(per(2) - 6);
    check("R5 no reset before expiry", 32'(wdt_sys_rst), 0);
    wait_n(1);
    check("R5 reset pulse starts", 32'(wdt_sys_rst), 1);
    hi = 1;
    for (int i = 0; i < RSTW; i++) begin
      wait_n(1);
      if (wdt_sys_rst) hi++;
    end
    check("R5 pulse width", 32'(hi), RSTW);
    rd(8'h08, v); check("R5 reload from TOP", v, per(1) - RSTW);
  endtask

  task automatic t_irq_then_reset();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'h3);           // E0, count = per(0)
    wait_n(per(0));
    check("R6 no irq before expiry", 32'(wdt_irq), 0);
    wait_n(1);
    check("R6 irq raised", 32'(wdt_irq), 1);
    check("R6 no reset at first expiry", 32'(wdt_sys_rst), 0);
    rd(8'h14, v); check("R9 clear read value", v, 1);   // E0+17
    check("R9 irq cleared", 32'(wdt_irq), 0);
    wait_n(per(0) - 1);
    check("R7 no reset early", 32'(wdt_sys_rst), 0);
    wait_n(1);
    check("R7 second expiry resets", 32'(wdt_sys_rst), 1);
  endtask

  task automatic t_irq_kick();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'h3);           // E0
    wait_n(per(0) + 1);
    check("R6 irq raised", 32'(wdt_irq), 1);
    wait_n(2);
    check("R6 irq held", 32'(wdt_irq), 1);
    rd(8'h10, v); check("R9 status read", v, 1);
    check("R9 status read keeps irq", 32'(wdt_irq), 1);
    wr(8'h0c, 32'h77);
    check("R8 wrong key keeps irq", 32'(wdt_irq), 1);
    wr(8'h0c, 32'h76);
    check("R8 kick clears irq", 32'(wdt_irq), 0);
    wait_n(per(0));
    check("R8 no irq yet", 32'(wdt_irq), 0);
    wait_n(1);
    check("R8 stage cleared: irq again", 32'(wdt_irq), 1);
    check("R8 stage cleared: no reset", 32'(wdt_sys_rst), 0);
  endtask

  task automatic t_top_change();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'h1);           // E0, count 15
    wr(8'h04, 32'h02);          // E1
    rd(8'h08, v); check("R11 count unaffected", v, per(0) - 1); // E2
    wr(8'h0c, 32'h76);          // E3
    rd(8'h08, v); check("R11 new TOP at restart", v, per(2));
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_direct_mode();
    t_irq_then_reset();
    t_irq_kick();
    t_top_change();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule